// File: doc/BRIEF.md
# Convert-Start Pulse Sequencer

This block controls a sampling converter that sleeps between conversions. One input, the convert-start line, does two jobs. Its rising edge wakes the converter and its falling edge samples the input and starts a conversion. The block counts how many clock cycles the line stays high. If that count is below the power-up time, the conversion still runs, but the result is marked invalid.

When the conversion time has passed, the block goes back to sleep. It then gives a one-cycle result strobe together with the channel number and the invalid flag. Each accepted pulse converts the next enabled channel, in ascending order, wrapping around. The analog core is modelled as a fixed conversion latency.

The pin mode is active only while the cycle-timer setting and the four pointer mode bits are all zero. In any other setting the convert-start line is ignored.

Top module: `cvs_seq`

## Requirements
- R1: After a synchronous active-low reset, `pwr_up`, `hold`, `busy`, `res_strobe` and `res_bad` are 0, and `ch_sel` equals N_CH-1.
- R2: A rising edge on `cs_in` is accepted only if three things hold when it is sampled: the pin mode is enabled, at least one `ch_en` bit is set, and no conversion or power-up is in progress. `pwr_up` is 1 in the cycle after the edge is sampled, and `busy` stays 0 until the falling edge.
- R3: The falling edge of `cs_in` after an accepted rise sets `busy` and `hold` to 1 from the next cycle. They stay 1 for exactly CONV_CYC cycles, with `pwr_up` also held at 1. After that, `pwr_up`, `busy` and `hold` all return to 0.
- R4: In the cycle after `busy` falls, `res_strobe` is 1 for exactly one cycle. In that cycle, `ch_sel` gives the converted channel and `res_bad` gives its invalid flag.
- R5: Let H be the number of consecutive clock edges at which `cs_in` is sampled high, counting from the rising edge. `res_bad` is 1 when H < PWRUP_CYC and 0 when H >= PWRUP_CYC. A short pulse still produces a full conversion.
- R6: `ch_en` bit i enables channel i, and `ch_en` is captured at the accepted rising edge. Each conversion takes the next enabled channel above the last converted one, wrapping from the highest to the lowest. `ch_sel` is the binary channel index and holds from the falling edge through the strobe.
- R7: With all `ch_en` bits 0, a `cs_in` pulse starts neither power-up nor conversion, and leaves the channel order unchanged.
- R8: The pin mode is enabled only when `cyc_cfg` is 0 and `ptr_mode` is 4'b0000. Otherwise a `cs_in` pulse is ignored.
- R9: A rising edge of `cs_in` during a conversion is ignored, and the conversion completes normally. If `cs_in` is still high when the conversion ends, no new power-up starts until a fresh rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_in | input | 1 | Convert-start line, synchronous to clk |
| ch_en | input | N_CH | Channel enable bits, bit i = channel i |
| cyc_cfg | input | TMR_W | Cycle-timer setting; must be zero for pin mode |
| ptr_mode | input | 4 | Pointer mode bits; must be zero for pin mode |
| pwr_up | output | 1 | Converter powered (power-up and conversion) |
| hold | output | 1 | Track-and-hold in hold |
| busy | output | 1 | Conversion in progress |
| ch_sel | output | CH_W | Channel being or last converted |
| res_strobe | output | 1 | One-cycle result-ready strobe |
| res_bad | output | 1 | Result invalid flag, valid with the strobe |

## Verification
The assertions assume that `cs_in` is already synchronous to `clk`, and that `ch_en`, `cyc_cfg` and `ptr_mode` are stable whenever a rising edge could be sampled. The checks on ignored edges read the configuration inputs in the same cycle as the edge. The bench drives every input on the falling clock edge from tasks. Configuration changes only while the block is asleep, except in the one scenario that changes `ch_en` after a rise on purpose. In that scenario a low-to-high edge in the same cycle as the end of a conversion is never driven.

// File: rtl/cvs_pkg.sv
// Package: shared state type for the convert-start sequencer.
// Assumes nothing beyond SystemVerilog-2017 enum support.
package cvs_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_WAKE  = 2'd1,
        ST_CONV  = 2'd2
    } cvs_state_e;
endpackage

// File: rtl/cvs_edge.sv
// Edge detector: registers the convert-start line once and reports
// rising and falling edges as one-cycle combinational pulses.
// Assumes sig is already synchronous to clk.
module cvs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    // Keep last sampled level of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/cvs_pick.sv
// Channel picker: returns the first enabled channel strictly above
// 'last', wrapping to the lowest. Returns 'last' if none is enabled.
// Assumes last < N_CH.
module cvs_pick #(
    parameter int N_CH = 4,
    parameter int CH_W = 2
) (
    input  logic [N_CH-1:0] en,
    input  logic [CH_W-1:0] last,
    output logic [CH_W-1:0] next
);
    // Scan upward from last+1 around the ring.
    always_comb begin
        logic found;
        int   idx;
        next  = last;
        found = 1'b0;
        for (int i = 1; i <= N_CH; i++) begin
            idx = (int'(last) + i) % N_CH;
            if (!found && en[idx]) begin
                next  = CH_W'(idx);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cvs_count.sv
// Saturating up-counter with clear priority over increment.
// Assumes MAX fits in W bits.
module cvs_count #(
    parameter int W   = 8,
    parameter int MAX = 255
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Clear, or count up and stop at MAX.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                 cnt <= '0;
        else if (inc && cnt != W'(MAX))    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cvs_seq.sv
// Convert-start sequencer top. Rising edge of cs_in wakes the converter,
// falling edge samples and starts a CONV_CYC-cycle conversion. The high
// time is compared with PWRUP_CYC to flag the result invalid. Channels
// rotate through ch_en, which is captured at the accepted rising edge.
// Assumes cs_in is synchronous to clk, PWRUP_CYC >= 1 and CONV_CYC >= 1.
module cvs_seq #(
    parameter int N_CH      = 4,
    parameter int PWRUP_CYC = 50,
    parameter int CONV_CYC  = 100,
    parameter int TMR_W     = 3,
    localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int CNT_MAX  = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC,
    localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_in,
    input  logic [N_CH-1:0]  ch_en,
    input  logic [TMR_W-1:0] cyc_cfg,
    input  logic [3:0]       ptr_mode,
    output logic             pwr_up,
    output logic             hold,
    output logic             busy,
    output logic [CH_W-1:0]  ch_sel,
    output logic             res_strobe,
    output logic             res_bad
);
    import cvs_pkg::*;

    cvs_state_e       state_q;
    logic [N_CH-1:0]  en_q;
    logic [CH_W-1:0]  ch_q;
    logic [CH_W-1:0]  ch_next;
    logic             bad_q;
    logic             strobe_q;
    logic             res_bad_q;
    logic             rise, fall;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;
    logic             mode_en;
    logic             conv_end;

    cvs_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (cs_in),
        .rise (rise),
        .fall (fall)
    );

    cvs_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick (
        .en  (en_q),
        .last(ch_q),
        .next(ch_next)
    );

    cvs_count #(.W(CNT_W), .MAX(CNT_MAX)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt)
    );

    // Pin mode qualifier from the timer and pointer mode settings.
    assign mode_en  = (cyc_cfg == '0) && (ptr_mode == 4'b0000);
    // Last conversion cycle.
    assign conv_end = (state_q == ST_CONV) && (cnt == CNT_W'(CONV_CYC - 1));

    // Counter control: count high time while waking, elapsed time while converting.
    always_comb begin
        cnt_clr = (state_q == ST_SLEEP) || ((state_q == ST_WAKE) && fall);
        cnt_inc = ((state_q == ST_WAKE) && cs_in) || (state_q == ST_CONV);
    end

    // Main sequencing: sleep -> wake -> convert -> sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            en_q    <= '0;
            ch_q    <= CH_W'(N_CH - 1);
            bad_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SLEEP: if (rise && mode_en && (|ch_en)) begin
                    state_q <= ST_WAKE;
                    en_q    <= ch_en;
                end
                ST_WAKE: if (fall) begin
                    state_q <= ST_CONV;
                    bad_q   <= (cnt < CNT_W'(PWRUP_CYC - 1));
                    ch_q    <= ch_next;
                end
                ST_CONV: if (conv_end) state_q <= ST_SLEEP;
                default: state_q <= ST_SLEEP;
            endcase
        end
    end

    // Result strobe and invalid flag, issued as the conversion ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q  <= 1'b0;
            res_bad_q <= 1'b0;
        end else begin
            strobe_q <= conv_end;
            if (conv_end) res_bad_q <= bad_q;
        end
    end

    assign pwr_up     = (state_q != ST_SLEEP);
    assign busy       = (state_q == ST_CONV);
    assign hold       = (state_q == ST_CONV);
    assign ch_sel     = ch_q;
    assign res_strobe = strobe_q;
    assign res_bad    = res_bad_q;
endmodule

// File: rtl/cvs_seq_chk.sv
// Checker for cvs_seq: port-level timing properties, bound to the top.
// Assumes inputs are synchronous to clk.
module cvs_seq_chk #(
    parameter int N_CH     = 4,
    parameter int CONV_CYC = 100,
    parameter int TMR_W    = 3,
    parameter int CH_W     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_in,
    input logic [N_CH-1:0]  ch_en,
    input logic [TMR_W-1:0] cyc_cfg,
    input logic [3:0]       ptr_mode,
    input logic             pwr_up,
    input logic             hold,
    input logic             busy,
    input logic [CH_W-1:0]  ch_sel,
    input logic             res_strobe,
    input logic             res_bad
);
    logic [31:0] busy_run;

    // Length of the current or just-ended busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= '0;
    end

    // R3
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == 32'(CONV_CYC));
    // R3
    busy_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pwr_up && hold));
    // R2
    wake_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pwr_up));
    // R4
    strobe_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> res_strobe);
    // R4
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_strobe |=> !res_strobe);
    // R6
    ch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ch_sel));
    // R7
    no_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_up && ch_en == '0) |=> !pwr_up);
    // R8
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_up && (cyc_cfg != '0 || ptr_mode != 4'b0000)) |=> !pwr_up);
    // R9
    back_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(res_strobe)) |=> (busy || !pwr_up));
endmodule

bind cvs_seq cvs_seq_chk #(
    .N_CH(N_CH), .CONV_CYC(CONV_CYC), .TMR_W(TMR_W), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .ch_en(ch_en),
    .cyc_cfg(cyc_cfg), .ptr_mode(ptr_mode), .pwr_up(pwr_up), .hold(hold),
    .busy(busy), .ch_sel(ch_sel), .res_strobe(res_strobe), .res_bad(res_bad)
);

// File: tb/tb_cvs_seq.sv
// Directed bench for cvs_seq: one task per scenario, checks at negedge.
module tb_cvs_seq;
    localparam int N_CH = 4;
    localparam int PW   = 8;
    localparam int CV   = 12;
    localparam int CH_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_in = 1'b0;
    logic [N_CH-1:0] ch_en = '0;
    logic [2:0] cyc_cfg = '0;
    logic [3:0] ptr_mode = '0;
    logic pwr_up, hold, busy, res_strobe, res_bad;
    logic [CH_W-1:0] ch_sel;

    int n_chk = 0;
    int n_fail = 0;
    int exp_last = N_CH - 1;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cvs_seq #(.N_CH(N_CH), .PWRUP_CYC(PW), .CONV_CYC(CV), .TMR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .ch_en(ch_en),
        .cyc_cfg(cyc_cfg), .ptr_mode(ptr_mode), .pwr_up(pwr_up), .hold(hold),
        .busy(busy), .ch_sel(ch_sel), .res_strobe(res_strobe), .res_bad(res_bad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference: next enabled channel above 'last', wrapping.
    function automatic int ref_next(input int last, input logic [N_CH-1:0] en);
        int c = last;
        repeat (N_CH) begin
            c = (c == N_CH - 1) ? 0 : c + 1;
            if (en[c]) return c;
        end
        return last;
    endfunction

    // Accepted pulse held high for h sampled edges; check whole conversion.
    task automatic pulse(input int h, input logic [N_CH-1:0] en_at_rise, input string tag);
        int run = 0;
        int exp_ch;
        bit exp_bad;
        exp_ch  = ref_next(exp_last, en_at_rise);
        exp_bad = (h < PW);
        cs_in = 1'b1;
        @(negedge clk);
        chk(pwr_up == 1'b1 && busy == 1'b0, {"R2 wake ", tag}, {pwr_up, busy}, 2);
        repeat (h - 1) @(negedge clk);
        cs_in = 1'b0;
        @(negedge clk);
        chk(busy && hold && pwr_up, {"R3 start ", tag}, {busy, hold, pwr_up}, 7);
        while (busy && run < CV + 5) begin
            run++;
            @(negedge clk);
        end
        chk(run == CV, {"R3 length ", tag}, run, CV);
        chk(!pwr_up && !hold, {"R3 sleep ", tag}, {pwr_up, hold}, 0);
        chk(res_strobe == 1'b1, {"R4 strobe ", tag}, res_strobe, 1);
        chk(int'(ch_sel) == exp_ch, {"R6 channel ", tag}, ch_sel, exp_ch);
        chk(res_bad == exp_bad, {"R5 invalid ", tag}, res_bad, exp_bad);
        exp_last = exp_ch;
        @(negedge clk);
        chk(res_strobe == 1'b0, {"R4 one cycle ", tag}, res_strobe, 0);
    endtask

    // Pulse that must be ignored: nothing powers up, no strobe, channel kept.
    task automatic ignored(input string tag);
        int seen = 0;
        cs_in = 1'b1;
        repeat (PW + 2) begin
            @(negedge clk);
            if (pwr_up || busy || res_strobe) seen++;
        end
        cs_in = 1'b0;
        repeat (CV + 2) begin
            @(negedge clk);
            if (pwr_up || busy || res_strobe) seen++;
        end
        chk(seen == 0, tag, seen, 0);
        chk(int'(ch_sel) == exp_last, {tag, " channel kept"}, ch_sel, exp_last);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pwr_up, hold, busy, res_strobe, res_bad} == 5'b0, "R1 outputs low",
            {pwr_up, hold, busy, res_strobe, res_bad}, 0);
        chk(int'(ch_sel) == N_CH - 1, "R1 channel", ch_sel, N_CH - 1);
    endtask

    task automatic t_sequence();
        ch_en = 4'b0101;
        pulse(PW, ch_en, "seq a");
        pulse(PW, ch_en, "seq b");
        pulse(PW + 10, ch_en, "seq wrap");
        ch_en = 4'b1111;
        pulse(PW, ch_en, "all 1");
        pulse(PW, ch_en, "all 2");
    endtask

    task automatic t_short();
        ch_en = 4'b0010;
        pulse(PW - 1, ch_en, "R5 boundary short");
        pulse(1, ch_en, "R5 minimal");
        pulse(PW, ch_en, "R5 boundary ok");
    endtask

    task automatic t_ignore();
        ch_en = 4'b0000;
        ignored("R7 no channels");
        ch_en = 4'b1000;
        cyc_cfg = 3'd1;
        ignored("R8 timer set");
        cyc_cfg = 3'd0;
        ptr_mode = 4'b0010;
        ignored("R8 mode bits set");
        ptr_mode = 4'b0000;
    endtask

    task automatic t_capture();
        logic [N_CH-1:0] en_rise;
        int exp_ch;
        int seen = 0;
        int run = 0;
        ch_en   = 4'b1000;
        en_rise = ch_en;
        exp_ch  = ref_next(exp_last, en_rise);
        cs_in = 1'b1;
        @(negedge clk);
        ch_en = 4'b0001;
        repeat (PW) @(negedge clk);
        cs_in = 1'b0;
        @(negedge clk);
        chk(int'(ch_sel) == exp_ch, "R6 enables captured at rise", ch_sel, exp_ch);
        exp_last = exp_ch;
        // R9: a rise during conversion, then held high past the end.
        repeat (2) @(negedge clk);
        cs_in = 1'b1;
        @(negedge clk);
        cs_in = 1'b0;
        @(negedge clk);
        cs_in = 1'b1;
        run = 4;
        while (busy && run < CV + 5) begin
            run++;
            @(negedge clk);
        end
        chk(run == CV, "R9 conversion length kept", run, CV);
        chk(res_strobe == 1'b1, "R9 strobe after ignored rise", res_strobe, 1);
        repeat (PW + 2) begin
            @(negedge clk);
            if (pwr_up) seen++;
        end
        chk(seen == 0, "R9 held line does not rewake", seen, 0);
        cs_in = 1'b0;
        repeat (2) @(negedge clk);
        ch_en = 4'b0001;
        pulse(PW, ch_en, "R9 fresh rise");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequence();
        t_short();
        t_ignore();
        t_capture();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule